// File: doc/BRIEF.md
# Virtual Channel Ownership Guard

This block sits between the host write path and a single physical command queue that many clients share. The low 23 bits of each host write address select both a client and a location. The top 7 bits name one of 128 virtual channels. The remaining 16 bits are an offset inside that channel's 64 KB window. Because each client is handed its own window, the channel number of a write identifies who issued it.

At any moment at most one channel owns the physical queue. A write from the owner goes straight through to the queue. A write from any other channel is held in the block, and the host path stalls. The block then raises a level interrupt that records the channel and offset of the write that faulted. A management agent services the interrupt. It can move ownership to the faulting channel by writing the owner register, and it then pulses a resume strobe. On that strobe the held write goes to the queue. If the owner register holds no valid channel, nothing owns the queue and every write faults.

Top module: `vcg_guard`

## Requirements
- R1: The channel number of a write is address bits [22:16] and its offset is bits [15:0]. A forwarded write appears on `q_chan` and `q_off` split in exactly this way.
- R2: If `wr_ready` is high and a write arrives from the valid owner channel, then in the next cycle `q_valid` is high for one cycle with the write's data, and `wr_ready` stays high.
- R3: If `wr_ready` is high and a write arrives from a channel that is not the valid owner, it is not forwarded. In the next cycle `irq` is high, `wr_ready` is low, and `flt_chan` and `flt_off` hold that write's channel and offset.
- R4: While `wr_ready` is low, host writes are ignored. Nothing is forwarded unless a resume succeeds, and `flt_chan` and `flt_off` do not change.
- R5: `irq` is a level. It stays high until a cycle with `ctl_ack` or a successful resume. An acknowledge clears `irq` but leaves the host path stalled.
- R6: A `ctl_resume` pulse while stalled, when the registered owner is valid and equals `flt_chan`, forwards the held write once in the next cycle. The data and offset are those of the held write. In that same cycle `irq` clears and `wr_ready` returns high.
- R7: A `ctl_resume` pulse while stalled, when the held channel is not the valid owner, forwards nothing. The path stays stalled and `irq` is high in the next cycle, even if an acknowledge came in the same cycle.
- R8: After reset, and after any owner write with `own_set_valid` low, no channel owns the queue and every write faults as in R3.
- R9: An owner write (`own_set` high) takes effect in the next cycle and can be read back on `own_valid` and `own_chan`. A resume in the same cycle as an owner write is judged against the previous owner.
- R10: Reset state: `wr_ready` is high; `irq`, `q_valid`, `own_valid`, `flt_chan` and `flt_off` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | 23 | Device-relative write address |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | High when a write is accepted; low while a fault is pending |
| own_set | input | 1 | Load the owner register |
| own_set_valid | input | 1 | Valid bit for the new owner; 0 means no owner |
| own_set_chan | input | 7 | New owner channel |
| ctl_resume | input | 1 | Pulse that retries the held write |
| ctl_ack | input | 1 | Pulse that clears the interrupt |
| irq | output | 1 | Level interrupt to the management agent |
| flt_chan | output | 7 | Channel of the last faulting write |
| flt_off | output | 16 | Offset of the last faulting write |
| own_valid | output | 1 | Owner register valid bit |
| own_chan | output | 7 | Owner register channel |
| q_valid | output | 1 | One-cycle write strobe to the physical queue |
| q_chan | output | 7 | Channel of the forwarded write |
| q_off | output | 16 | Offset of the forwarded write |
| q_data | output | 32 | Data of the forwarded write |

## Verification
The properties assume that every control input is a known value and is read once per rising edge. They also assume that a request counts only in a cycle where `wr_ready` is high. The host is not required to hold a request while the path is stalled. The bench drives all inputs on the falling edge, so each value is settled and free of X when the clock rises. The random agent model issues acknowledges, resumes and owner writes only as single-cycle pulses. It steers part of the traffic toward the current owner and the held channel, so that both hits and successful resumes occur often.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HELD = 1'b1
    } gate_e;
endpackage

// File: rtl/vcg_addr_split.sv
module vcg_addr_split #(
    parameter int ADDR_W = 23,
    parameter int CHAN_W = 7
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic [CHAN_W-1:0]        chan,
    output logic [ADDR_W-CHAN_W-1:0] off
);
    localparam int OFF_W = ADDR_W - CHAN_W;

    // Channel sits in the top bits, offset fills the rest of the window
    assign chan = addr[ADDR_W-1 -: CHAN_W];
    assign off  = addr[OFF_W-1:0];
endmodule

// File: rtl/vcg_owner_reg.sv
module vcg_owner_reg #(
    parameter int CHAN_W = 7,
    parameter int NPROBE = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic                          set_valid,
    input  logic [CHAN_W-1:0]             set_chan,
    input  logic [NPROBE-1:0][CHAN_W-1:0] probe,
    output logic [NPROBE-1:0]             hit,
    output logic                          owner_valid,
    output logic [CHAN_W-1:0]             owner_chan
);
    typedef struct packed {
        logic              vld;
        logic [CHAN_W-1:0] chan;
    } own_t;

    own_t own_d, own_q;

    always_comb begin
        own_d = own_q;
        if (set_en) begin
            own_d.vld  = set_valid;
            own_d.chan = set_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
        end else begin
            own_q <= own_d;
        end
    end

    // One comparator per lookup port
    for (genvar g = 0; g < NPROBE; g++) begin : g_probe
        assign hit[g] = own_q.vld && (own_q.chan == probe[g]);
    end

    assign owner_valid = own_q.vld;
    assign owner_chan  = own_q.chan;
endmodule

// File: rtl/vcg_fault_ctl.sv
module vcg_fault_ctl
    import vcg_pkg::*;
#(
    parameter int CHAN_W = 7,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [CHAN_W-1:0] acc_chan,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              acc_hit,
    input  logic              held_hit,
    input  logic              resume,
    input  logic              ack,
    output logic              acc_ready,
    output logic              irq,
    output logic [CHAN_W-1:0] rec_chan,
    output logic [OFF_W-1:0]  rec_off,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic [OFF_W-1:0]  out_off,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        gate_e             st;
        logic              irq;
        logic [CHAN_W-1:0] rec_chan;
        logic [OFF_W-1:0]  rec_off;
        logic [DATA_W-1:0] rec_data;
        logic              ov;
        logic [CHAN_W-1:0] oc;
        logic [OFF_W-1:0]  oo;
        logic [DATA_W-1:0] od;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.ov = 1'b0;
        case (ctl_q.st)
            GATE_OPEN: begin
                if (acc_valid) begin
                    if (acc_hit) begin
                        ctl_d.ov = 1'b1;
                        ctl_d.oc = acc_chan;
                        ctl_d.oo = acc_off;
                        ctl_d.od = acc_data;
                    end else begin
                        // Capture the offending write and stall the host
                        ctl_d.st       = GATE_HELD;
                        ctl_d.irq      = 1'b1;
                        ctl_d.rec_chan = acc_chan;
                        ctl_d.rec_off  = acc_off;
                        ctl_d.rec_data = acc_data;
                    end
                end
            end
            GATE_HELD: begin
                if (ack) begin
                    ctl_d.irq = 1'b0;
                end
                if (resume) begin
                    if (held_hit) begin
                        ctl_d.ov  = 1'b1;
                        ctl_d.oc  = ctl_q.rec_chan;
                        ctl_d.oo  = ctl_q.rec_off;
                        ctl_d.od  = ctl_q.rec_data;
                        ctl_d.st  = GATE_OPEN;
                        ctl_d.irq = 1'b0;
                    end else begin
                        // Retry still from a non-owner: signal again
                        ctl_d.irq = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.st = GATE_OPEN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign acc_ready = (ctl_q.st == GATE_OPEN);
    assign irq       = ctl_q.irq;
    assign rec_chan  = ctl_q.rec_chan;
    assign rec_off   = ctl_q.rec_off;
    assign out_valid = ctl_q.ov;
    assign out_chan  = ctl_q.oc;
    assign out_off   = ctl_q.oo;
    assign out_data  = ctl_q.od;
endmodule

// File: rtl/vcg_guard.sv
module vcg_guard #(
    parameter int ADDR_W = 23,
    parameter int CHAN_W = 7,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     wr_ready,
    input  logic                     own_set,
    input  logic                     own_set_valid,
    input  logic [CHAN_W-1:0]        own_set_chan,
    input  logic                     ctl_resume,
    input  logic                     ctl_ack,
    output logic                     irq,
    output logic [CHAN_W-1:0]        flt_chan,
    output logic [ADDR_W-CHAN_W-1:0] flt_off,
    output logic                     own_valid,
    output logic [CHAN_W-1:0]        own_chan,
    output logic                     q_valid,
    output logic [CHAN_W-1:0]        q_chan,
    output logic [ADDR_W-CHAN_W-1:0] q_off,
    output logic [DATA_W-1:0]        q_data
);
    localparam int OFF_W  = ADDR_W - CHAN_W;
    localparam int NPROBE = 2;
    localparam int P_ACC  = 0;
    localparam int P_HELD = 1;

    logic [CHAN_W-1:0]             acc_chan;
    logic [OFF_W-1:0]              acc_off;
    logic [NPROBE-1:0][CHAN_W-1:0] probe;
    logic [NPROBE-1:0]             hit;

    vcg_addr_split #(
        .ADDR_W (ADDR_W),
        .CHAN_W (CHAN_W)
    ) u_split (
        .addr (wr_addr),
        .chan (acc_chan),
        .off  (acc_off)
    );

    // Incoming channel and the held channel are both compared with the owner
    assign probe[P_ACC]  = acc_chan;
    assign probe[P_HELD] = flt_chan;

    vcg_owner_reg #(
        .CHAN_W (CHAN_W),
        .NPROBE (NPROBE)
    ) u_owner (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (own_set),
        .set_valid   (own_set_valid),
        .set_chan    (own_set_chan),
        .probe       (probe),
        .hit         (hit),
        .owner_valid (own_valid),
        .owner_chan  (own_chan)
    );

    vcg_fault_ctl #(
        .CHAN_W (CHAN_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (wr_valid),
        .acc_chan  (acc_chan),
        .acc_off   (acc_off),
        .acc_data  (wr_data),
        .acc_hit   (hit[P_ACC]),
        .held_hit  (hit[P_HELD]),
        .resume    (ctl_resume),
        .ack       (ctl_ack),
        .acc_ready (wr_ready),
        .irq       (irq),
        .rec_chan  (flt_chan),
        .rec_off   (flt_off),
        .out_valid (q_valid),
        .out_chan  (q_chan),
        .out_off   (q_off),
        .out_data  (q_data)
    );
endmodule

// File: rtl/vcg_guard_chk.sv
module vcg_guard_chk #(
    parameter int ADDR_W = 23,
    parameter int CHAN_W = 7,
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_valid,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     wr_ready,
    input logic                     own_set,
    input logic                     own_set_valid,
    input logic [CHAN_W-1:0]        own_set_chan,
    input logic                     ctl_resume,
    input logic                     ctl_ack,
    input logic                     irq,
    input logic [CHAN_W-1:0]        flt_chan,
    input logic [ADDR_W-CHAN_W-1:0] flt_off,
    input logic                     own_valid,
    input logic [CHAN_W-1:0]        own_chan,
    input logic                     q_valid,
    input logic [CHAN_W-1:0]        q_chan,
    input logic [ADDR_W-CHAN_W-1:0] q_off,
    input logic [DATA_W-1:0]        q_data
);
    localparam int OFF_W = ADDR_W - CHAN_W;

    logic [CHAN_W-1:0] in_chan;
    logic              in_hit;
    logic              held_hit;
    assign in_chan  = wr_addr[ADDR_W-1 -: CHAN_W];
    assign in_hit   = own_valid && (own_chan == in_chan);
    assign held_hit = own_valid && (own_chan == flt_chan);

    a_r1_split: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && in_hit |=>
            q_chan == $past(in_chan) && q_off == $past(wr_addr[OFF_W-1:0]));

    a_r2_owner_passes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && in_hit |=>
            q_valid && wr_ready && q_data == $past(wr_data));

    a_r3_stranger_traps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !in_hit |=>
            irq && !wr_ready && !q_valid && flt_chan == $past(in_chan));

    a_r4_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready && !ctl_resume |=>
            !q_valid && !wr_ready && $stable(flt_chan) && $stable(flt_off));

    a_r5_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctl_ack && !ctl_resume |=> irq);

    a_r5_irq_only_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !wr_ready);

    a_r6_resume_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready && ctl_resume && held_hit |=>
            q_valid && wr_ready && !irq && q_chan == $past(flt_chan)
            && q_off == $past(flt_off));

    a_r7_resume_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready && ctl_resume && !held_hit |=> irq && !wr_ready && !q_valid);

    a_r8_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !own_valid && wr_valid && wr_ready |=> irq);

    a_r9_owner_load: assert property (@(posedge clk) disable iff (!rst_n)
        own_set |=> own_valid == $past(own_set_valid) && own_chan == $past(own_set_chan));
endmodule

bind vcg_guard vcg_guard_chk #(
    .ADDR_W (ADDR_W),
    .CHAN_W (CHAN_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/test_vcg_guard.sv
module test_vcg_guard;
    localparam int ADDR_W = 23;
    localparam int CHAN_W = 7;
    localparam int DATA_W = 32;
    localparam int OFF_W  = ADDR_W - CHAN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic wr_ready;
    logic own_set = 1'b0;
    logic own_set_valid = 1'b0;
    logic [CHAN_W-1:0] own_set_chan = '0;
    logic ctl_resume = 1'b0;
    logic ctl_ack = 1'b0;
    logic irq;
    logic [CHAN_W-1:0] flt_chan;
    logic [OFF_W-1:0] flt_off;
    logic own_valid;
    logic [CHAN_W-1:0] own_chan;
    logic q_valid;
    logic [CHAN_W-1:0] q_chan;
    logic [OFF_W-1:0] q_off;
    logic [DATA_W-1:0] q_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vcg_guard #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)) i_vcg_guard (.*);

    // Reference model state (mirrors registered outputs)
    logic m_ov = 1'b0;
    logic [CHAN_W-1:0] m_oc = '0;
    logic m_flt = 1'b0;
    logic m_irq = 1'b0;
    logic [CHAN_W-1:0] m_hc = '0;
    logic [OFF_W-1:0] m_ho = '0;
    logic [DATA_W-1:0] m_hd = '0;
    logic m_qv = 1'b0;
    logic [CHAN_W-1:0] m_qc = '0;
    logic [OFF_W-1:0] m_qo = '0;
    logic [DATA_W-1:0] m_qd = '0;
    string qtag = "R10";

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [CHAN_W-1:0] c, input logic [OFF_W-1:0] o);
        return {c, o};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(32'(wr_ready), 32'(!m_flt), "R4", "wr_ready");
        chk(32'(irq), 32'(m_irq), "R5", "irq");
        chk(32'(q_valid), 32'(m_qv), qtag, "q_valid");
        if (m_qv) begin
            chk(32'(q_chan), 32'(m_qc), "R1", "q_chan");
            chk(32'(q_off), 32'(m_qo), "R1", "q_off");
            chk(q_data, m_qd, qtag, "q_data");
        end
        chk(32'(flt_chan), 32'(m_hc), "R3", "flt_chan");
        chk(32'(flt_off), 32'(m_ho), "R3", "flt_off");
        chk(32'(own_valid), 32'(m_ov), "R9", "own_valid");
        if (m_ov) chk(32'(own_chan), 32'(m_oc), "R9", "own_chan");
    endtask

    // One clock: drive at falling edge, advance model, check at next falling edge
    task automatic cyc(input logic v, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic ow, input logic ov, input logic [CHAN_W-1:0] oc,
                       input logic rs, input logic ak);
        logic n_ov, n_flt, n_irq, n_qv;
        logic [CHAN_W-1:0] n_oc, n_hc, n_qc, c;
        logic [OFF_W-1:0] n_ho, n_qo;
        logic [DATA_W-1:0] n_hd, n_qd;
        string t;
        wr_valid = v; wr_addr = a; wr_data = d;
        own_set = ow; own_set_valid = ov; own_set_chan = oc;
        ctl_resume = rs; ctl_ack = ak;
        n_ov = m_ov; n_oc = m_oc; n_flt = m_flt; n_irq = m_irq;
        n_hc = m_hc; n_ho = m_ho; n_hd = m_hd;
        n_qv = 1'b0; n_qc = m_qc; n_qo = m_qo; n_qd = m_qd;
        t = m_flt ? "R4" : "R2";
        c = a[ADDR_W-1 -: CHAN_W];
        if (!m_flt) begin
            if (v) begin
                if (m_ov && c == m_oc) begin
                    n_qv = 1'b1; n_qc = c; n_qo = a[OFF_W-1:0]; n_qd = d; t = "R2";
                end else begin
                    n_flt = 1'b1; n_irq = 1'b1; n_hc = c; n_ho = a[OFF_W-1:0]; n_hd = d;
                    t = m_ov ? "R3" : "R8";
                end
            end
        end else begin
            if (ak) n_irq = 1'b0;
            if (rs) begin
                if (m_ov && m_hc == m_oc) begin
                    n_qv = 1'b1; n_qc = m_hc; n_qo = m_ho; n_qd = m_hd;
                    n_flt = 1'b0; n_irq = 1'b0; t = "R6";
                end else begin
                    n_irq = 1'b1; t = "R7";
                end
            end
        end
        if (ow) begin
            n_ov = ov; n_oc = oc;
        end
        @(posedge clk);
        m_ov = n_ov; m_oc = n_oc; m_flt = n_flt; m_irq = n_irq;
        m_hc = n_hc; m_ho = n_ho; m_hd = n_hd;
        m_qv = n_qv; m_qc = n_qc; m_qo = n_qo; m_qd = n_qd; qtag = t;
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [CHAN_W-1:0] c, input logic [OFF_W-1:0] o, input logic [DATA_W-1:0] d);
        cyc(1'b1, mk_addr(c, o), d, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    endtask
    task automatic set_owner(input logic v, input logic [CHAN_W-1:0] c);
        cyc(1'b0, '0, '0, 1'b1, v, c, 1'b0, 1'b0);
    endtask
    task automatic resume();
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    endtask
    task automatic ack();
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20250520));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        chk(32'(wr_ready), 32'd1, "R10", "wr_ready");
        chk(32'(irq), 32'd0, "R10", "irq");
        chk(32'(q_valid), 32'd0, "R10", "q_valid");
        chk(32'(own_valid), 32'd0, "R10", "own_valid");
        chk(32'(flt_chan), 32'd0, "R10", "flt_chan");
        chk(32'(flt_off), 32'd0, "R10", "flt_off");

        // R8: no owner after reset, any write traps
        wr(7'd3, 16'h0010, 32'hA5A5_0001);
        ack();                                   // R5: ack clears irq, still stalled
        set_owner(1'b1, 7'd3);                   // R9
        resume();                                // R6: held write goes through
        // R1/R2: owner writes at window edges
        wr(7'd3, 16'h0000, 32'h1111_0000);
        wr(7'd3, 16'hFFFF, 32'h1111_FFFF);
        set_owner(1'b1, 7'd127);
        wr(7'd127, 16'h8001, 32'hDEAD_BEEF);
        // R3: stranger write traps
        wr(7'd9, 16'h1234, 32'h0909_0909);
        // R4: writes while stalled are ignored
        wr(7'd127, 16'h0002, 32'h7777_7777);
        wr(7'd5, 16'h0003, 32'h5555_5555);
        // R7: resume while still not owner, with ack the same cycle
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b1);
        // R9: owner write and resume in one cycle uses old owner
        cyc(1'b0, '0, '0, 1'b1, 1'b1, 7'd9, 1'b1, 1'b0);
        resume();                                // R6 now succeeds
        // R8: cleared valid bit means no owner
        set_owner(1'b0, 7'd9);
        wr(7'd9, 16'h0044, 32'h4444_4444);
        set_owner(1'b1, 7'd9);
        resume();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic v, ow, ov, rs, ak;
            logic [CHAN_W-1:0] c, oc;
            int r;
            r  = int'($urandom_range(0, 99));
            v  = ($urandom_range(0, 3) != 0);
            c  = (r < 60 && m_ov) ? m_oc : CHAN_W'($urandom_range(0, 127));
            ow = ($urandom_range(0, 9) == 0);
            ov = ($urandom_range(0, 7) != 0);
            oc = ($urandom_range(0, 1) == 0) ? m_hc : CHAN_W'($urandom_range(0, 127));
            rs = m_flt && ($urandom_range(0, 3) == 0);
            ak = m_flt && ($urandom_range(0, 2) == 0);
            cyc(v, mk_addr(c, OFF_W'($urandom)), $urandom, ow, ov, oc, rs, ak);
        end
        cyc(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
        finish_run();
    end
endmodule